// File: doc/BRIEF.md
# Two-Rail Charge-Pump Clock Controller

This block drives the clocks of a negative and a positive charge pump while a memory write is in progress. A programmable divider on the system clock stands in for a free-running ring oscillator. Each pump gets a non-overlapping two-phase clock: phase one is high for a set number of cycles, then one idle cycle, then phase two for the same number of cycles, then one more idle cycle. Each pump's level detector returns a halt signal. The halt is high once its rail has reached target, and while it is high no new pump cycle starts.

Every time write mode is entered, both pumps begin on the long divider setting. This slow start spreads the inrush current while the rails first ramp. After a rail has reached target once, its pump switches to the short divider setting for steady-state top-up. Write-mode entry also follows a fixed order. The negative pump starts first. The positive pump is not allowed to run until the negative rail has reached target. A ready flag for each rail reports that its rail has reached target at least once in the current write session.

Top module: `pump_clk_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, all four phase outputs and both ready flags are low.
- R2: While write mode is low, every phase output and both ready flags are low from the next clock edge on, whatever the other inputs do.
- R3: Each pump cycle consists of phase one high for D cycles, then one cycle with both phases low, then phase two high for D cycles, then one cycle with both phases low. The two phases of a pump are never high together.
- R4: Until a rail's ready flag is set, its pump uses D equal to the long divider input.
- R5: Once a rail's ready flag is set, every cycle that pump starts afterwards uses D equal to the short divider input.
- R6: The positive pump produces no phase pulse while the negative ready flag is low.
- R7: A pump cycle starts only on an edge where write mode is high, the pump is permitted, and its halt input is low. A cycle that has already started runs to completion. While the halt input stays high, no further cycle starts.
- R8: A rail's ready flag goes high on the clock edge that samples its halt input high in write mode. For the positive rail, the negative ready flag must also already be high. The flag stays high until write mode goes low, and it is cleared on the next edge after that.
- R9: A divider input value of 0 or 1 is treated as 2.
- R10: D is latched when phase one begins and applies to both phases of that cycle. A change to a divider input takes effect at the next cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_mode | input | 1 | High while a write operation needs the pumps |
| neg_halt | input | 1 | Negative-rail detector: high when the rail is at or beyond target |
| pos_halt | input | 1 | Positive-rail detector: high when the rail is at or beyond target |
| long_div | input | DIV_W | Phase length in cycles used during ramp |
| short_div | input | DIV_W | Phase length in cycles used in steady state |
| neg_ph1 | output | 1 | Negative pump clock, phase one |
| neg_ph2 | output | 1 | Negative pump clock, phase two |
| pos_ph1 | output | 1 | Positive pump clock, phase one |
| pos_ph2 | output | 1 | Positive pump clock, phase two |
| neg_ready | output | 1 | Negative rail has reached target this write session |
| pos_ready | output | 1 | Positive rail has reached target this write session |

## Verification
A pump's first phase-one pulse appears one edge after the edge that samples permission and a low halt. Each phase then lasts D edges, and each idle gap lasts one edge. A ready flag rises on the same edge that samples its halt high, so the positive pump can start no sooner than the edge after the negative flag rises. The scoreboard does not depend on absolute cycle numbers. It measures each phase pulse at falling clock edges, from its rise to its fall, and compares the width against the next queued expectation. The driver changes halt and divider inputs one time step after a rising edge, and only once the monitor has consumed the phase-one pulse of the last wanted cycle; that way the boundary decision for that cycle is known. Ready flags are checked at the falling edge after the first and second rising edges that follow a halt or write-mode change.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

    localparam int NUM_PUMPS = 2;
    localparam int NEG_IDX   = 0;
    localparam int POS_IDX   = 1;
    localparam int MIN_DIV   = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_A,
        PH_GAP_A,
        PH_B,
        PH_GAP_B
    } phase_e;

    typedef struct packed {
        logic a;
        logic b;
    } pair_t;

    function automatic pair_t phase_outputs(input phase_e st);
        pair_t p;
        p.a = (st == PH_A);
        p.b = (st == PH_B);
        return p;
    endfunction

endpackage

// File: rtl/pcp_phase_engine.sv
module pcp_phase_engine
    import pcp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output pair_t            ph
);

    localparam logic [DIV_W-1:0] MIN_W = DIV_W'(MIN_DIV);

    typedef struct packed {
        phase_e           st;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] width;
    } eng_t;

    eng_t             cur_q;
    eng_t             nxt;
    logic [DIV_W-1:0] width_in;

    // values below the floor behave as the floor
    assign width_in = (div_sel < MIN_W) ? MIN_W : div_sel;

    always_comb begin
        nxt = cur_q;
        unique case (cur_q.st)
            PH_IDLE: begin
                if (run) begin
                    nxt.st    = PH_A;
                    nxt.width = width_in;
                    nxt.cnt   = width_in - 1'b1;
                end
            end
            PH_A: begin
                if (cur_q.cnt == '0) nxt.st = PH_GAP_A;
                else                 nxt.cnt = cur_q.cnt - 1'b1;
            end
            PH_GAP_A: begin
                nxt.st  = PH_B;
                nxt.cnt = cur_q.width - 1'b1;
            end
            PH_B: begin
                if (cur_q.cnt == '0) nxt.st = PH_GAP_B;
                else                 nxt.cnt = cur_q.cnt - 1'b1;
            end
            PH_GAP_B: begin
                if (run) begin
                    nxt.st    = PH_A;
                    nxt.width = width_in;
                    nxt.cnt   = width_in - 1'b1;
                end else begin
                    nxt.st = PH_IDLE;
                end
            end
            default: nxt.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur_q.st    <= PH_IDLE;
            cur_q.cnt   <= '0;
            cur_q.width <= MIN_W;
        end else begin
            cur_q <= nxt;
        end
    end

    assign ph = phase_outputs(cur_q.st);

endmodule

// File: rtl/pcp_rail_tracker.sv
module pcp_rail_tracker (
    input  logic clk,
    input  logic rst,
    input  logic wr_mode,
    input  logic permit,
    input  logic at_target,
    output logic ready
);

    always_ff @(posedge clk) begin
        if (rst || !wr_mode) ready <= 1'b0;
        else if (permit && at_target) ready <= 1'b1;
    end

endmodule

// File: rtl/pump_clk_ctrl.sv
module pump_clk_ctrl
    import pcp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_mode,
    input  logic             neg_halt,
    input  logic             pos_halt,
    input  logic [DIV_W-1:0] long_div,
    input  logic [DIV_W-1:0] short_div,
    output logic             neg_ph1,
    output logic             neg_ph2,
    output logic             pos_ph1,
    output logic             pos_ph2,
    output logic             neg_ready,
    output logic             pos_ready
);

    logic [NUM_PUMPS-1:0] halt_v;
    logic [NUM_PUMPS-1:0] ready_v;
    logic [NUM_PUMPS-1:0] permit_v;
    pair_t                ph_v [NUM_PUMPS];

    assign halt_v[NEG_IDX] = neg_halt;
    assign halt_v[POS_IDX] = pos_halt;

    for (genvar i = 0; i < NUM_PUMPS; i++) begin : g_pump
        logic             run;
        logic [DIV_W-1:0] div_sel;

        // pump i may start only after every earlier rail has reached target
        if (i == 0) begin : g_first
            assign permit_v[i] = 1'b1;
        end else begin : g_later
            assign permit_v[i] = ready_v[i-1];
        end

        assign run     = wr_mode && permit_v[i] && !halt_v[i];
        assign div_sel = ready_v[i] ? short_div : long_div;

        pcp_rail_tracker u_track (
            .clk       (clk),
            .rst       (rst),
            .wr_mode   (wr_mode),
            .permit    (permit_v[i]),
            .at_target (halt_v[i]),
            .ready     (ready_v[i])
        );

        pcp_phase_engine #(.DIV_W(DIV_W)) u_eng (
            .clk     (clk),
            .rst     (rst),
            .clear   (!wr_mode),
            .run     (run),
            .div_sel (div_sel),
            .ph      (ph_v[i])
        );
    end

    assign neg_ph1   = ph_v[NEG_IDX].a;
    assign neg_ph2   = ph_v[NEG_IDX].b;
    assign pos_ph1   = ph_v[POS_IDX].a;
    assign pos_ph2   = ph_v[POS_IDX].b;
    assign neg_ready = ready_v[NEG_IDX];
    assign pos_ready = ready_v[POS_IDX];

endmodule

// File: rtl/pump_clk_ctrl_chk.sv
module pump_clk_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic wr_mode,
    input logic neg_halt,
    input logic pos_halt,
    input logic neg_ph1,
    input logic neg_ph2,
    input logic pos_ph1,
    input logic pos_ph2,
    input logic neg_ready,
    input logic pos_ready
);

    assert_no_overlap_neg_R3: assert property (@(posedge clk) disable iff (rst)
        !(neg_ph1 && neg_ph2));

    assert_no_overlap_pos_R3: assert property (@(posedge clk) disable iff (rst)
        !(pos_ph1 && pos_ph2));

    assert_gap_after_a_neg_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(neg_ph1) |-> !neg_ph2);

    assert_gap_after_a_pos_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pos_ph1) |-> !pos_ph2);

    assert_idle_outside_write_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_mode |=> !(neg_ph1 || neg_ph2 || pos_ph1 || pos_ph2 || neg_ready || pos_ready));

    assert_neg_first_R6: assert property (@(posedge clk) disable iff (rst)
        !neg_ready |-> !(pos_ph1 || pos_ph2));

    assert_start_needs_low_neg_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(neg_ph1) |-> ($past(wr_mode) && !$past(neg_halt)));

    assert_start_needs_low_pos_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pos_ph1) |-> ($past(wr_mode) && !$past(pos_halt)));

    assert_neg_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (neg_ready && wr_mode) |=> neg_ready);

    assert_pos_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (pos_ready && wr_mode) |=> pos_ready);

    assert_ready_order_R8: assert property (@(posedge clk) disable iff (rst)
        pos_ready |-> neg_ready);

endmodule

bind pump_clk_ctrl pump_clk_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_mode   (wr_mode),
    .neg_halt  (neg_halt),
    .pos_halt  (pos_halt),
    .neg_ph1   (neg_ph1),
    .neg_ph2   (neg_ph2),
    .pos_ph1   (pos_ph1),
    .pos_ph2   (pos_ph2),
    .neg_ready (neg_ready),
    .pos_ready (pos_ready)
);

// File: tb/test_pump_clk_ctrl.sv
`timescale 1ns/1ps
module test_pump_clk_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    typedef struct {
        int    width;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_mode = 1'b0;
    logic             neg_halt = 1'b0;
    logic             pos_halt = 1'b0;
    logic [DIV_W-1:0] long_div = 8'd5;
    logic [DIV_W-1:0] short_div = 8'd3;
    logic             neg_ph1, neg_ph2, pos_ph1, pos_ph2, neg_ready, pos_ready;

    exp_t q [2][$];
    int   run_len [2][2];
    int   total = 0;
    int   failed = 0;
    int   pulses = 0;
    int   early_pos = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pump_clk_ctrl #(.DIV_W(DIV_W)) i_pump_clk_ctrl (
        .clk(clk), .rst(rst), .wr_mode(wr_mode),
        .neg_halt(neg_halt), .pos_halt(pos_halt),
        .long_div(long_div), .short_div(short_div),
        .neg_ph1(neg_ph1), .neg_ph2(neg_ph2),
        .pos_ph1(pos_ph1), .pos_ph2(pos_ph2),
        .neg_ready(neg_ready), .pos_ready(pos_ready)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // monitor: measure each phase pulse and compare with the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [1:0] cur [2];
            cur[0] = {neg_ph1, neg_ph2};
            cur[1] = {pos_ph1, pos_ph2};
            if ((pos_ph1 || pos_ph2) && !neg_ready) early_pos++;
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 2; k++) begin
                    if (cur[p][1-k]) begin
                        run_len[p][k]++;
                    end else if (run_len[p][k] > 0) begin
                        pulses++;
                        if (q[p].size() == 0) begin
                            check(0, "R7 unexpected pulse", run_len[p][k], 0);
                        end else begin
                            exp_t e;
                            e = q[p].pop_front();
                            check(run_len[p][k] == e.width, e.tag, run_len[p][k], e.width);
                        end
                        run_len[p][k] = 0;
                    end
                end
            end
        end
    end

    task automatic push(input int p, input int cycles, input int w, input string tag);
        for (int i = 0; i < 2*cycles; i++) begin
            exp_t e;
            e.width = w;
            e.tag   = tag;
            q[p].push_back(e);
        end
    endtask

    task automatic wait_q(input int p, input int left);
        while (q[p].size() > left) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: got 1 expected 0");
        summary();
    end

    initial begin
        int snap;
        repeat (3) step();
        @(negedge clk);
        check({neg_ph1, neg_ph2, pos_ph1, pos_ph2, neg_ready, pos_ready} == 6'b0, "R1 reset idle",
              {neg_ph1, neg_ph2, pos_ph1, pos_ph2, neg_ready, pos_ready}, 0);
        step();
        rst = 1'b0;
        @(negedge clk);
        check({neg_ph1, neg_ph2, pos_ph1, pos_ph2, neg_ready, pos_ready} == 6'b0, "R1 after release",
              {neg_ph1, neg_ph2, pos_ph1, pos_ph2, neg_ready, pos_ready}, 0);

        // outside write mode nothing runs even with both halts low
        repeat (20) step();
        check(pulses == 0, "R2 no pulses outside write", pulses, 0);
        check({neg_ready, pos_ready} == 2'b00, "R2 ready low outside write", {neg_ready, pos_ready}, 0);

        // ramp: negative pump first on the long setting
        push(0, 3, 5, "R4 neg long width");
        push(1, 3, 5, "R4 pos long width");
        wr_mode = 1'b1;
        wait_q(0, 1);
        check(neg_ready == 1'b0, "R8 neg ready before target", neg_ready, 0);
        neg_halt = 1'b1;
        @(negedge clk);
        check(neg_ready == 1'b0, "R8 neg ready waits for edge", neg_ready, 0);
        @(posedge clk);
        @(negedge clk);
        check(neg_ready == 1'b1, "R8 neg ready on sampled halt", neg_ready, 1);
        wait_q(1, 1);
        pos_halt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(pos_ready == 1'b1, "R8 pos ready on sampled halt", pos_ready, 1);
        repeat (16) step();
        check(q[0].size() == 0 && q[1].size() == 0, "R7 halt stops after current cycle",
              q[0].size() + q[1].size(), 0);
        snap = pulses;
        repeat (20) step();
        check(pulses == snap, "R7 no new cycle while halted", pulses - snap, 0);

        // steady state: short setting, change mid-cycle takes effect at boundary
        push(0, 1, 3, "R5 neg short width");
        push(0, 1, 6, "R10 neg new short at boundary");
        neg_halt = 1'b0;
        wait_q(0, 3);
        short_div = 8'd6;
        wait_q(0, 1);
        neg_halt = 1'b1;
        repeat (20) step();
        check(q[0].size() == 0, "R10 neg queue drained", q[0].size(), 0);

        // divider floor
        short_div = 8'd0;
        push(0, 1, 2, "R9 short of 0 acts as 2");
        neg_halt = 1'b0;
        wait_q(0, 1);
        neg_halt = 1'b1;
        repeat (10) step();
        short_div = 8'd1;
        push(1, 2, 2, "R9 short of 1 acts as 2");
        pos_halt = 1'b0;
        wait_q(1, 3);
        wait_q(1, 1);
        pos_halt = 1'b1;
        repeat (12) step();
        check(q[1].size() == 0, "R5 pos short drained", q[1].size(), 0);

        // leaving write mode clears flags and holds pumps idle
        wr_mode = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({neg_ready, pos_ready} == 2'b00, "R8 ready cleared on write exit", {neg_ready, pos_ready}, 0);
        neg_halt = 1'b0;
        pos_halt = 1'b0;
        snap = pulses;
        repeat (20) step();
        check(pulses == snap, "R2 idle after write exit", pulses - snap, 0);

        // re-entry: long again, positive ready needs negative first
        long_div = 8'd4;
        pos_halt = 1'b1;
        push(0, 2, 4, "R4 neg long after re-entry");
        wr_mode = 1'b1;
        repeat (6) step();
        @(negedge clk);
        check(pos_ready == 1'b0, "R8 pos ready needs neg ready", pos_ready, 0);
        wait_q(0, 1);
        neg_halt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(neg_ready == 1'b1 && pos_ready == 1'b0, "R8 neg ready before pos",
              {neg_ready, pos_ready}, 2'b10);
        @(posedge clk);
        @(negedge clk);
        check(pos_ready == 1'b1, "R8 pos ready one edge later", pos_ready, 1);
        repeat (15) step();
        check(q[0].size() == 0 && q[1].size() == 0, "R3 all queued pulses seen",
              q[0].size() + q[1].size(), 0);
        check(early_pos == 0, "R6 pos idle until neg ready", early_pos, 0);
        done = 1;
        summary();
    end

endmodule